// File: doc/BRIEF.md
# I2C Data and Command Register Port

This block is the processor-facing side of an I2C controller's data path. A processor write to the data/command address carries an 11-bit command word. The word goes into an eight-entry transmit command queue, which the bit-level bus engine drains through a valid/ready handshake. A processor read of the same address pops the oldest byte from an eight-entry receive queue. The engine fills that queue through a second valid/ready handshake.

The two directions of the one address are deliberately asymmetric. Writes are checked against three pieces of controller state before they are queued:
- whether the previous command was a general call;
- whether the special-address mode is still enabled;
- whether a remote master has a read request pending.

A read command that conflicts with this state is discarded and a sticky abort interrupt is raised. The engine can then serve the remote read request. Sticky overflow and underflow flags record writes to a full command queue and reads of an empty receive queue. A second address clears the flags when 1s are written to it.

Top module: `i2c_cmd_port`

## Requirements
- R1: A write to address 0 that is not rejected and finds the command queue not full enqueues bits 10:0 of the bus word. Bit 10 is restart, bit 9 is stop, bit 8 is the direction (1 = read, 0 = write) and bits 7:0 are data. Bits 31:11 are ignored. The queue head appears on `tx_cmd` with `tx_valid` high in the cycle after the write.
- R2: When a queued command has direction bit 8 = 1, its data bits 7:0 are stored as zero, whatever the bus carried.
- R3: A read of address 0 returns the oldest received byte on `bus_rdata[7:0]` in the same cycle and removes it from the queue. Bits 31:8 always read as zero, and a read of any other address returns zero and removes nothing.
- R4: A write to address 0 with bit 8 = 1 while `slave_rd_req` is high is not queued, and `irq_abort` is high from the next cycle.
- R5: A write to address 0 with bit 8 = 1 while both `gen_call_done` and `special_en` are high is not queued and raises `irq_abort`. With `special_en` low, the same write is queued.
- R6: A write to address 0 with bit 8 = 0 is queued even while `slave_rd_req` is high; this is the byte a slave transmitter returns.
- R7: A write that passes validation but finds eight entries queued is dropped, and `flag_overflow` is high from the next cycle.
- R8: A read of address 0 with the receive queue empty returns zero and sets `flag_underflow` from the next cycle.
- R9: A write to address 1 clears `irq_abort` if bit 0 is set, `flag_overflow` if bit 1 is set and `flag_underflow` if bit 2 is set, from the next cycle. The flags otherwise hold their value.
- R10: Both queues keep first-in first-out order with eight entries each. `rx_ready` is low only when eight received bytes are waiting, and a byte offered while `rx_ready` is low is not taken.
- R11: After reset both queues are empty (`tx_valid` low, `rx_ready` high) and all three flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write access, 0 = read access |
| bus_addr | input | 2 | Register select: 0 data/command, 1 flag clear |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| gen_call_done | input | 1 | Previous command was a general call |
| special_en | input | 1 | Special-address mode enabled |
| slave_rd_req | input | 1 | Remote master read request pending |
| tx_valid | output | 1 | Command queue holds an entry |
| tx_ready | input | 1 | Engine takes the head command |
| tx_cmd | output | 11 | Head command word {restart, stop, read, data} |
| rx_valid | input | 1 | Engine offers a received byte |
| rx_ready | output | 1 | Receive queue has room |
| rx_data | input | 8 | Received byte |
| irq_abort | output | 1 | Sticky transmit-abort interrupt |
| flag_overflow | output | 1 | Sticky command-queue overflow |
| flag_underflow | output | 1 | Sticky receive-queue underflow |

## Verification
On every cycle, the assertions check four things:
- a rejected read command raises the abort flag and never grows the command queue;
- a validated write to a full queue raises overflow;
- an empty-queue read returns zero and raises underflow;
- a clear write drops the abort flag, and the upper read bits stay zero.

Only the bench's scenarios can show the rest: the exact content and order of queued commands, the zeroing of read-command data, the acceptance of slave-transmitter bytes during a pending request, and receive back-pressure at eight entries. A queue-based model is compared against every output on every clock for these.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;
  localparam int CMD_W  = 11;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              restart;
    logic              stop;
    logic              rd;
    logic [BYTE_W-1:0] data;
  } cmd_word_t;

  // bit positions in the clear register and in the flag vector
  localparam int FLG_ABORT = 0;
  localparam int FLG_OVF   = 1;
  localparam int FLG_UDF   = 2;
  localparam int FLG_N     = 3;

  localparam logic [1:0] REG_DATA  = 2'd0;
  localparam logic [1:0] REG_CLEAR = 2'd1;
endpackage

// File: rtl/cmd_sync_fifo.sv
module cmd_sync_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, wr_ptr_nxt, rd_ptr, rd_ptr_nxt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             do_push, do_pop;

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_comb begin
    wr_ptr_nxt = do_push ? bump(wr_ptr) : wr_ptr;
    rd_ptr_nxt = do_pop  ? bump(rd_ptr) : rd_ptr;
    cnt_nxt    = count;
    if (do_push && !do_pop)      cnt_nxt = count + CNT_W'(1);
    else if (do_pop && !do_push) cnt_nxt = count - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr_nxt;
      rd_ptr <= rd_ptr_nxt;
      count  <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= wdata;
  end
endmodule

// File: rtl/cmd_validator.sv
module cmd_validator (
  input  logic wr_hit,
  input  logic is_read,
  input  logic gen_call_done,
  input  logic special_en,
  input  logic slave_rd_req,
  input  logic queue_full,
  output logic accept,
  output logic abort_set,
  output logic overflow_set
);
  logic conflict;

  // a read command cannot follow a general call in special mode,
  // nor be started while a remote master waits for data
  always_comb begin
    conflict     = is_read && (slave_rd_req || (gen_call_done && special_en));
    abort_set    = wr_hit && conflict;
    overflow_set = wr_hit && !conflict && queue_full;
    accept       = wr_hit && !conflict && !queue_full;
  end
endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] q
);
  logic [N-1:0] q_nxt;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_comb q_nxt[i] = set[i] | (q[i] & ~clr[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= q_nxt[i];
    end
  end
endmodule

// File: rtl/i2c_cmd_port.sv
module i2c_cmd_port
  import i2c_cmd_pkg::*;
#(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 8,
  localparam int TX_LW   = $clog2(TX_DEPTH + 1),
  localparam int RX_LW   = $clog2(RX_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              gen_call_done,
  input  logic              special_en,
  input  logic              slave_rd_req,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [CMD_W-1:0]  tx_cmd,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              irq_abort,
  output logic              flag_overflow,
  output logic              flag_underflow
);
  logic              wr_data_hit, rd_data_hit, clr_hit;
  cmd_word_t         wr_word, push_word;
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [BYTE_W-1:0] rx_head;
  logic [TX_LW-1:0]  tx_level;
  logic [RX_LW-1:0]  rx_level;
  logic              abort_set, ovf_set;
  logic [FLG_N-1:0]  flag_set, flag_clr, flag_q;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata[DATA_W-1:CMD_W];

  // address decode
  always_comb begin
    wr_data_hit = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(REG_DATA));
    rd_data_hit = bus_sel && !bus_wr && (bus_addr == ADDR_W'(REG_DATA));
    clr_hit     = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(REG_CLEAR));
  end

  // command word capture; data of a read command is not kept
  always_comb begin
    wr_word   = cmd_word_t'(bus_wdata[CMD_W-1:0]);
    push_word = wr_word;
    if (wr_word.rd) push_word.data = '0;
  end

  cmd_validator u_val (
    .wr_hit        (wr_data_hit),
    .is_read       (wr_word.rd),
    .gen_call_done (gen_call_done),
    .special_en    (special_en),
    .slave_rd_req  (slave_rd_req),
    .queue_full    (tx_full),
    .accept        (tx_push),
    .abort_set     (abort_set),
    .overflow_set  (ovf_set)
  );

  assign tx_valid = !tx_empty;
  assign tx_pop   = tx_valid && tx_ready;

  cmd_sync_fifo #(.WIDTH(CMD_W), .DEPTH(TX_DEPTH)) u_txq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (tx_push),
    .wdata (push_word),
    .pop   (tx_pop),
    .rdata (tx_cmd),
    .count (tx_level),
    .full  (tx_full),
    .empty (tx_empty)
  );

  assign rx_ready = !rx_full;
  assign rx_push  = rx_valid && !rx_full;
  assign rx_pop   = rd_data_hit && !rx_empty;

  cmd_sync_fifo #(.WIDTH(BYTE_W), .DEPTH(RX_DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (rx_push),
    .wdata (rx_data),
    .pop   (rx_pop),
    .rdata (rx_head),
    .count (rx_level),
    .full  (rx_full),
    .empty (rx_empty)
  );

  // read path: only the byte lane carries data
  always_comb begin
    bus_rdata = '0;
    if (rx_pop) bus_rdata[BYTE_W-1:0] = rx_head;
  end

  always_comb begin
    flag_set            = '0;
    flag_set[FLG_ABORT] = abort_set;
    flag_set[FLG_OVF]   = ovf_set;
    flag_set[FLG_UDF]   = rd_data_hit && rx_empty;
    flag_clr            = clr_hit ? bus_wdata[FLG_N-1:0] : '0;
  end

  sticky_flags #(.N(FLG_N)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .q     (flag_q)
  );

  assign irq_abort      = flag_q[FLG_ABORT];
  assign flag_overflow  = flag_q[FLG_OVF];
  assign flag_underflow = flag_q[FLG_UDF];
endmodule

// File: rtl/i2c_cmd_port_chk.sv
module i2c_cmd_port_chk #(
  parameter int ADDR_W   = 2,
  parameter int DATA_W   = 32,
  parameter int TX_DEPTH = 8,
  parameter int TX_LW    = 4,
  parameter int RX_LW    = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              gen_call_done,
  input logic              special_en,
  input logic              slave_rd_req,
  input logic              irq_abort,
  input logic              flag_overflow,
  input logic              flag_underflow,
  input logic [TX_LW-1:0]  tx_level,
  input logic [RX_LW-1:0]  rx_level
);
  logic wr0, rd0, clr1, unused_chk;
  assign wr0  = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(0));
  assign rd0  = bus_sel && !bus_wr && (bus_addr == ADDR_W'(0));
  assign clr1 = bus_sel &&  bus_wr && (bus_addr == ADDR_W'(1));
  assign unused_chk = ^{bus_wdata[DATA_W-1:9], bus_wdata[7:1]};

  assert_abort_remote_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && bus_wdata[8] && slave_rd_req) |=> (irq_abort && tx_level <= $past(tx_level)));

  assert_abort_gencall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && bus_wdata[8] && gen_call_done && special_en) |=> (irq_abort && tx_level <= $past(tx_level)));

  assert_rdata_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:8] == '0);

  assert_overflow_on_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && !bus_wdata[8] && tx_level == TX_LW'(TX_DEPTH)) |=> flag_overflow);

  assert_underflow_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && rx_level == '0) |-> (bus_rdata == '0));

  assert_underflow_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd0 && rx_level == '0) |=> flag_underflow);

  assert_clear_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr1 && bus_wdata[0]) |=> !irq_abort);
endmodule

bind i2c_cmd_port i2c_cmd_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TX_DEPTH(TX_DEPTH), .TX_LW(TX_LW), .RX_LW(RX_LW)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .bus_sel        (bus_sel),
  .bus_wr         (bus_wr),
  .bus_addr       (bus_addr),
  .bus_wdata      (bus_wdata),
  .bus_rdata      (bus_rdata),
  .gen_call_done  (gen_call_done),
  .special_en     (special_en),
  .slave_rd_req   (slave_rd_req),
  .irq_abort      (irq_abort),
  .flag_overflow  (flag_overflow),
  .flag_underflow (flag_underflow),
  .tx_level       (tx_level),
  .rx_level       (rx_level)
);

// File: tb/tb_i2c_cmd_port.sv
module tb_i2c_cmd_port;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        gen_call_done, special_en, slave_rd_req;
  logic        tx_valid, tx_ready;
  logic [10:0] tx_cmd;
  logic        rx_valid, rx_ready;
  logic [7:0]  rx_data;
  logic        irq_abort, flag_overflow, flag_underflow;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  i2c_cmd_port dut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // behavioural reference model
  logic [10:0] m_tx[$];
  logic [7:0]  m_rx[$];
  bit m_ab, m_ov, m_ud;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx.delete(); m_rx.delete();
      m_ab = 0; m_ov = 0; m_ud = 0;
    end else begin
      int  tn, rn;
      bit  s_ab, s_ov, s_ud, do_push;
      logic [10:0] pw;
      tn = m_tx.size(); rn = m_rx.size();
      s_ab = 0; s_ov = 0; s_ud = 0; do_push = 0; pw = '0;
      if (bus_sel && bus_wr && bus_addr == 2'd0) begin
        if (bus_wdata[8] && (slave_rd_req || (gen_call_done && special_en))) s_ab = 1;
        else if (tn == 8) s_ov = 1;
        else begin
          do_push = 1;
          pw = bus_wdata[8] ? {bus_wdata[10:8], 8'h00} : bus_wdata[10:0];
        end
      end
      if (tn > 0 && tx_ready) void'(m_tx.pop_front());
      if (do_push) m_tx.push_back(pw);
      if (bus_sel && !bus_wr && bus_addr == 2'd0) begin
        if (rn > 0) void'(m_rx.pop_front());
        else s_ud = 1;
      end
      if (rx_valid && rn < 8) m_rx.push_back(rx_data);
      if (bus_sel && bus_wr && bus_addr == 2'd1) begin
        if (bus_wdata[0]) m_ab = 0;
        if (bus_wdata[1]) m_ov = 0;
        if (bus_wdata[2]) m_ud = 0;
      end
      m_ab = m_ab | s_ab; m_ov = m_ov | s_ov; m_ud = m_ud | s_ud;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [31:0] exp_rd;
      exp_rd = '0;
      if (bus_sel && !bus_wr && bus_addr == 2'd0 && m_rx.size() > 0) exp_rd = {24'h0, m_rx[0]};
      chk("R3 rdata", bus_rdata, exp_rd);
      chk("R10 tx_valid", {31'h0, tx_valid}, {31'h0, m_tx.size() > 0});
      if (m_tx.size() > 0) chk("R1 tx_cmd", {21'h0, tx_cmd}, {21'h0, m_tx[0]});
      chk("R10 rx_ready", {31'h0, rx_ready}, {31'h0, m_rx.size() < 8});
      chk("R4 irq_abort", {31'h0, irq_abort}, {31'h0, m_ab});
      chk("R7 flag_overflow", {31'h0, flag_overflow}, {31'h0, m_ov});
      chk("R8 flag_underflow", {31'h0, flag_underflow}, {31'h0, m_ud});
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    cyc(1);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #2;
    bus_sel = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    rst_n = 0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    gen_call_done = 0; special_en = 0; slave_rd_req = 0;
    tx_ready = 0; rx_valid = 0; rx_data = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    cyc(1);
    chk("R11 tx_valid", {31'h0, tx_valid}, 32'h0);
    chk("R11 rx_ready", {31'h0, rx_ready}, 32'h1);
    chk("R11 flags", {29'h0, irq_abort, flag_overflow, flag_underflow}, 32'h0);

    // R1: upper junk ignored, fields kept
    wr(2'd0, 32'hFFFF_FEA5);
    chk("R1 head", {21'h0, tx_cmd}, 32'h6A5);
    // R2: read command with data
    wr(2'd0, 32'h0000_01AB);
    for (int i = 0; i < 6; i++) wr(2'd0, 32'h0C0 + i);
    chk("R10 full no overflow", {31'h0, flag_overflow}, 32'h0);
    wr(2'd0, 32'h0000_00FF);
    chk("R7 overflow", {31'h0, flag_overflow}, 32'h1);
    wr(2'd1, 32'h0000_0002);
    chk("R9 overflow cleared", {31'h0, flag_overflow}, 32'h0);
    tx_ready = 1; cyc(1); tx_ready = 0;
    chk("R2 data zeroed", {21'h0, tx_cmd}, 32'h100);
    tx_ready = 1; cyc(10); tx_ready = 0;
    chk("R10 drained", {31'h0, tx_valid}, 32'h0);

    // R4 / R6 with remote read request pending
    slave_rd_req = 1;
    wr(2'd0, 32'h0000_0133);
    chk("R4 abort", {31'h0, irq_abort}, 32'h1);
    chk("R4 not queued", {31'h0, tx_valid}, 32'h0);
    wr(2'd0, 32'h0000_0055);
    chk("R6 slave byte queued", {21'h0, tx_cmd}, 32'h055);
    slave_rd_req = 0;
    wr(2'd1, 32'h0000_0001);
    chk("R9 abort cleared", {31'h0, irq_abort}, 32'h0);
    tx_ready = 1; cyc(2); tx_ready = 0;

    // R5 general call
    gen_call_done = 1; special_en = 1;
    wr(2'd0, 32'h0000_0100);
    chk("R5 abort", {31'h0, irq_abort}, 32'h1);
    chk("R5 not queued", {31'h0, tx_valid}, 32'h0);
    special_en = 0;
    wr(2'd0, 32'h0000_0500);
    chk("R5 queued without special", {21'h0, tx_cmd}, 32'h500);
    gen_call_done = 0;
    wr(2'd1, 32'h0000_0007);
    tx_ready = 1; cyc(2); tx_ready = 0;

    // R8 empty read
    rd(2'd0, d);
    chk("R8 empty read zero", d, 32'h0);
    chk("R8 underflow", {31'h0, flag_underflow}, 32'h1);
    wr(2'd1, 32'h0000_0004);
    chk("R9 underflow cleared", {31'h0, flag_underflow}, 32'h0);

    // R3 / R10 receive path
    for (int i = 0; i < 10; i++) begin
      rx_valid = 1; rx_data = 8'h30 + 8'(i);
      cyc(1);
    end
    rx_valid = 0;
    chk("R10 rx full", {31'h0, rx_ready}, 32'h0);
    rd(2'd1, d);
    chk("R3 other addr zero", d, 32'h0);
    for (int i = 0; i < 8; i++) begin
      rd(2'd0, d);
      chk("R3 rx order", d, 32'h30 + i);
    end
    chk("R8 no underflow yet", {31'h0, flag_underflow}, 32'h0);
    chk("R10 rx empty again", {31'h0, rx_ready}, 32'h1);

    // concurrent push and pop on the command queue
    tx_ready = 1;
    for (int i = 0; i < 5; i++) wr(2'd0, 32'h200 + i);
    cyc(3);
    tx_ready = 0;
    cyc(2);
    finish_run();
  end
endmodule